// File: doc/BRIEF.md
# Command-Word Watchdog Timer

A watchdog timer driven through two word-wide registers. A 20-bit down-counter decrements once per cycle in which the tick-enable input is high. Software never sets enable bits. It writes whole 16-bit command words to a control register, and each word halts, resumes, opens or closes the reload gate, refills the counter to full scale, or acknowledges an expiry. A second register holds the reload value. It is 16 bits wide and is aligned to the top of the counter, so the value that software sees is the counter divided by sixteen. It accepts writes only while the gate is open.

When the running counter reaches zero, the block sets a sticky interrupt flag, raises a one-clock reset request and stops counting. To force an immediate reset, software opens the gate, loads a count of 1 and resumes. The counter then expires on the sixteenth tick.

The register port is a plain single-cycle write strobe with a combinational read. A bus bridge, the tick source and the system reset controller lie outside the block.

Top module: `cmd_wdt`

## Requirements
- R1: After reset the counter is stopped, the gate is closed, and the count register reads 0xFFFF (counter all ones). The irq_o and rst_req_o outputs are low.
- R2: Writing 0x3877 to the control register (offset 0x0) halts counting. Writing 0x4A4B resumes counting from the held value. While halted, ticks leave the counter unchanged.
- R3: Writing 0xAB00 to the control register opens the reload gate and writing 0xAB01 closes it. Each takes effect from the next cycle. A count-register write (offset 0x4) made while the gate is closed is ignored.
- R4: A count-register write with the gate open loads the counter with wdata_i[15:0] in bits [19:4] and zeros in bits [3:0]. A read at offset 0x4 returns counter bits [19:4] in rdata_o[15:0], with the upper bits zero. A read at offset 0x0 returns zero.
- R5: Writing 0xDEAF to the control register sets all 20 counter bits to one, whatever the state of the gate.
- R6: When a tick arrives while the counter is running and holds 0 or 1, and no load or refill is written in that cycle, the counter becomes 0. On the same edge irq_o is set, rst_req_o goes high for exactly one cycle, and counting stops unless a resume command is written in that same cycle.
- R7: irq_o stays high until 0x7482 is written to the control register. An expiry in the same cycle as that write leaves irq_o set.
- R8: A control write whose low 16 bits match no command has no effect. Bits [31:16] of a control write are ignored when the command is matched.
- R9: A load or refill in the same cycle as a tick overrides the decrement. A read in that cycle returns the value before the tick. Halt and resume change whether the counter runs from the next cycle on.
- R10: With the gate opened, a count of 1 loaded and counting resumed, the fifteenth tick leaves rst_req_o low and the sixteenth tick raises it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable (one pulse per counter step) |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Sticky expiry interrupt |
| rst_req_o | output | 1 | One-cycle reset request on expiry |

## Verification
The counter value is visible at offset 0x4 in the same cycle, so a wrong decrement, a wrongly honoured load or a missed refill shows up on the next read of that register. It shows one sixteenth of the counter, so a fault confined to the low four bits first appears as an early or late expiry, up to sixteen ticks later. A fault in the lock or run state has no direct read-back. It shows up as a count that moves or stays put against expectation on the next tick or write. A fault in the expiry logic shows on irq_o and rst_req_o one edge after the terminal tick.

// File: rtl/cmd_wdt_pkg.sv
package cmd_wdt_pkg;
  localparam int unsigned CMD_W = 16;

  localparam logic [CMD_W-1:0] CMD_HALT = 16'h3877;
  localparam logic [CMD_W-1:0] CMD_RUN  = 16'h4A4B;
  localparam logic [CMD_W-1:0] CMD_ACK  = 16'h7482;
  localparam logic [CMD_W-1:0] CMD_OPEN = 16'hAB00;
  localparam logic [CMD_W-1:0] CMD_SHUT = 16'hAB01;
  localparam logic [CMD_W-1:0] CMD_FULL = 16'hDEAF;

  typedef struct packed {
    logic halt;
    logic run;
    logic ack;
    logic open;
    logic shut;
    logic full;
    logic load;
  } cmd_t;
endpackage

// File: rtl/cmd_wdt_decode.sv
module cmd_wdt_decode
  import cmd_wdt_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] CTRL_OFF = 4'h0,
  parameter logic [ADDR_W-1:0] CNT_OFF  = 4'h4
) (
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic              locked_i,
  output cmd_t              cmd_o
);
  logic ctrl_wr;
  assign ctrl_wr = we_i && (addr_i == CTRL_OFF);

  always_comb begin
    cmd_o = '0;
    if (ctrl_wr) begin
      unique case (cmd_i)
        CMD_HALT: cmd_o.halt = 1'b1;
        CMD_RUN:  cmd_o.run  = 1'b1;
        CMD_ACK:  cmd_o.ack  = 1'b1;
        CMD_OPEN: cmd_o.open = 1'b1;
        CMD_SHUT: cmd_o.shut = 1'b1;
        CMD_FULL: cmd_o.full = 1'b1;
        default:  ;
      endcase
    end
    // reload gate: closed gate drops the write
    cmd_o.load = we_i && (addr_i == CNT_OFF) && !locked_i;
  end
endmodule

// File: rtl/cmd_wdt_lock.sv
module cmd_wdt_lock (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic open_i,
  input  logic shut_i,
  output logic locked_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     locked_o <= 1'b1;
    else if (open_i) locked_o <= 1'b0;
    else if (shut_i) locked_o <= 1'b1;
  end
endmodule

// File: rtl/cmd_wdt_counter.sv
module cmd_wdt_counter #(
  parameter int unsigned CNT_W  = 20,
  parameter int unsigned FRAC_W = 4,
  localparam int unsigned VIS_W = CNT_W - FRAC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             halt_i,
  input  logic             run_i,
  input  logic             full_i,
  input  logic             load_i,
  input  logic [VIS_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             running_o,
  output logic             expire_o
);
  logic             step;
  logic             at_end;
  logic [CNT_W-1:0] cnt_d;

  assign step     = running_o && tick_i;
  assign at_end   = (cnt_o <= CNT_W'(1));
  assign expire_o = step && at_end && !full_i && !load_i;

  always_comb begin
    cnt_d = cnt_o;
    if (full_i)      cnt_d = '1;
    else if (load_i) cnt_d = {load_val_i, {FRAC_W{1'b0}}};
    else if (step)   cnt_d = at_end ? '0 : cnt_o - CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o     <= '1;
      running_o <= 1'b0;
    end else begin
      cnt_o <= cnt_d;
      if (halt_i)        running_o <= 1'b0;
      else if (run_i)    running_o <= 1'b1;
      else if (expire_o) running_o <= 1'b0;
    end
  end
endmodule

// File: rtl/cmd_wdt_expiry.sv
module cmd_wdt_expiry (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic ack_i,
  output logic irq_o,
  output logic rst_req_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o     <= 1'b0;
      rst_req_o <= 1'b0;
    end else begin
      rst_req_o <= expire_i;
      // a new expiry beats a same-cycle acknowledge
      if (expire_i)   irq_o <= 1'b1;
      else if (ack_i) irq_o <= 1'b0;
    end
  end
endmodule

// File: rtl/cmd_wdt.sv
module cmd_wdt
  import cmd_wdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 20,
  parameter int unsigned FRAC_W = 4,
  parameter logic [ADDR_W-1:0] CTRL_OFF = 4'h0,
  parameter logic [ADDR_W-1:0] CNT_OFF  = 4'h4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  localparam int unsigned VIS_W = CNT_W - FRAC_W;

  cmd_t             cmd;
  logic             locked;
  logic             running;
  logic             expire;
  logic [CNT_W-1:0] cnt;
  logic             unused_wdata_hi;

  assign unused_wdata_hi = ^wdata_i[DATA_W-1:CMD_W];

  cmd_wdt_decode #(
    .ADDR_W(ADDR_W), .CTRL_OFF(CTRL_OFF), .CNT_OFF(CNT_OFF)
  ) u_decode (
    .we_i(we_i), .addr_i(addr_i), .cmd_i(wdata_i[CMD_W-1:0]),
    .locked_i(locked), .cmd_o(cmd)
  );

  cmd_wdt_lock u_lock (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .open_i(cmd.open), .shut_i(cmd.shut), .locked_o(locked)
  );

  cmd_wdt_counter #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_counter (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .halt_i(cmd.halt), .run_i(cmd.run), .full_i(cmd.full), .load_i(cmd.load),
    .load_val_i(wdata_i[VIS_W-1:0]),
    .cnt_o(cnt), .running_o(running), .expire_o(expire)
  );

  cmd_wdt_expiry u_expiry (
    .clk_i(clk_i), .rst_ni(rst_ni), .expire_i(expire), .ack_i(cmd.ack),
    .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == CNT_OFF) rdata_o[VIS_W-1:0] = cnt[CNT_W-1:FRAC_W];
  end
endmodule

// File: rtl/cmd_wdt_chk.sv
module cmd_wdt_chk
  import cmd_wdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CNT_W  = 20,
  parameter logic [ADDR_W-1:0] CTRL_OFF = 4'h0,
  parameter logic [ADDR_W-1:0] CNT_OFF  = 4'h4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [CMD_W-1:0]  cmd_i,
  input logic              irq_o,
  input logic              rst_req_o,
  input logic [CNT_W-1:0]  cnt_i,
  input logic              running_i,
  input logic              locked_i
);
  logic ctrl_wr;
  assign ctrl_wr = we_i && (addr_i == CTRL_OFF);

  assert_halted_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!running_i && !we_i) |=> $stable(cnt_i));

  assert_locked_ignore_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_i && we_i && addr_i == CNT_OFF && !(running_i && tick_i)) |=> $stable(cnt_i));

  assert_refill_full_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && cmd_i == CMD_FULL) |=> (cnt_i == '1));

  assert_expiry_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (cnt_i == '0 && irq_o));

  assert_single_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_req_o && !running_i) |=> !rst_req_o);

  assert_irq_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !(ctrl_wr && cmd_i == CMD_ACK)) |=> irq_o);
endmodule

bind cmd_wdt cmd_wdt_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .CTRL_OFF(CTRL_OFF), .CNT_OFF(CNT_OFF)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .we_i(we_i),
  .addr_i(addr_i), .cmd_i(wdata_i[15:0]), .irq_o(irq_o), .rst_req_o(rst_req_o),
  .cnt_i(cnt), .running_i(running), .locked_i(locked)
);

// File: tb/cmd_wdt_tb.sv
module cmd_wdt_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        we_i = 1'b0;
  logic [3:0]  addr_i = 4'h0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o, rst_req_o;

  int checks = 0;
  int failures = 0;

  // bench-side model state
  logic [19:0] m_cnt;
  logic        m_run, m_lock, m_irq, m_rst;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cmd_wdt u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  function automatic logic [31:0] exp_read(input logic [3:0] a);
    return (a == 4'h4) ? {16'h0, m_cnt[19:4]} : 32'h0;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic model(input bit we, input logic [3:0] a, input logic [31:0] d, input bit tk);
    bit ctl, halt, run, ack, opn, sht, full, load, step, expire;
    ctl  = we && a == 4'h0;
    halt = ctl && d[15:0] == 16'h3877;
    run  = ctl && d[15:0] == 16'h4A4B;
    ack  = ctl && d[15:0] == 16'h7482;
    opn  = ctl && d[15:0] == 16'hAB00;
    sht  = ctl && d[15:0] == 16'hAB01;
    full = ctl && d[15:0] == 16'hDEAF;
    load = we && a == 4'h4 && !m_lock;
    step = m_run && tk;
    expire = step && m_cnt <= 20'd1 && !full && !load;
    if (full)      m_cnt = 20'hFFFFF;
    else if (load) m_cnt = {d[15:0], 4'h0};
    else if (step) m_cnt = (m_cnt <= 20'd1) ? 20'd0 : m_cnt - 20'd1;
    if (halt)        m_run = 1'b0;
    else if (run)    m_run = 1'b1;
    else if (expire) m_run = 1'b0;
    if (opn)      m_lock = 1'b0;
    else if (sht) m_lock = 1'b1;
    if (expire)   m_irq = 1'b1;
    else if (ack) m_irq = 1'b0;
    m_rst = expire;
  endtask

  // one cycle: check outputs, drive, check read, advance model and clock
  task automatic step(input bit we, input logic [3:0] a, input logic [31:0] d, input bit tk);
    chk({31'h0, irq_o}, {31'h0, m_irq}, "R7 irq");
    chk({31'h0, rst_req_o}, {31'h0, m_rst}, "R6 rst_req");
    we_i = we; addr_i = a; wdata_i = d; tick_i = tk;
    #1;
    chk(rdata_o, exp_read(a), "R4 read");
    model(we, a, d, tk);
    @(posedge clk_i);
    @(negedge clk_i);
    we_i = 1'b0; tick_i = 1'b0;
  endtask

  task automatic ctrl(input logic [31:0] d); step(1'b1, 4'h0, d, 1'b0); endtask
  task automatic ld(input logic [15:0] v); step(1'b1, 4'h4, {16'h0, v}, 1'b0); endtask

  task automatic peek(input logic [15:0] exp, input string req);
    addr_i = 4'h4; we_i = 1'b0; #1;
    chk(rdata_o, {16'h0, exp}, req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    m_cnt = 20'hFFFFF; m_run = 0; m_lock = 1; m_irq = 0; m_rst = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1: reset state
    peek(16'hFFFF, "R1 reset count");
    chk({30'h0, irq_o, rst_req_o}, 32'h0, "R1 reset outputs");
    step(1'b0, 4'h4, 32'h0, 1'b1);
    peek(16'hFFFF, "R1 stopped after reset");

    // R3: closed gate ignores load
    ld(16'h0005);
    peek(16'hFFFF, "R3 locked write ignored");
    ctrl(32'h0000_AB00);
    ld(16'h0003);
    peek(16'h0003, "R3 unlocked write loads");
    chk(exp_read(4'h0), 32'h0, "R4 ctrl reads zero");
    step(1'b0, 4'h0, 32'h0, 1'b0);
    ctrl(32'h0000_AB01);
    ld(16'h0009);
    peek(16'h0003, "R3 relocked write ignored");

    // R8: unknown code no effect; upper bits ignored on a matched code
    ctrl(32'h0000_1234);
    step(1'b0, 4'h4, 32'h0, 1'b1);
    peek(16'h0003, "R8 unknown code leaves counter stopped");
    ctrl(32'hFFFF_4A4B);
    repeat (16) step(1'b0, 4'h4, 32'h0, 1'b1);
    peek(16'h0002, "R2 resume counts 16 ticks");
    ctrl(32'h5A5A_3877);
    repeat (5) step(1'b0, 4'h4, 32'h0, 1'b1);
    peek(16'h0002, "R2 halt holds count");

    // R5: refill without unlock
    ctrl(32'h0000_DEAF);
    peek(16'hFFFF, "R5 refill while locked");

    // R9: load beats same-cycle tick; read shows pre-tick value
    ctrl(32'h0000_4A4B);
    ctrl(32'h0000_AB00);
    step(1'b1, 4'h4, 32'h0000_0007, 1'b1);
    peek(16'h0007, "R9 load wins over tick");

    // R10: count of 1 expires on the 16th tick
    ld(16'h0001);
    repeat (15) step(1'b0, 4'h4, 32'h0, 1'b1);
    chk({31'h0, rst_req_o}, 32'h0, "R10 no request after 15 ticks");
    step(1'b0, 4'h4, 32'h0, 1'b1);
    chk({31'h0, rst_req_o}, 32'h1, "R10 request after 16 ticks");
    chk({31'h0, irq_o}, 32'h1, "R6 irq set on expiry");
    step(1'b0, 4'h4, 32'h0, 1'b1);
    chk({31'h0, rst_req_o}, 32'h0, "R6 request is one cycle");
    peek(16'h0000, "R6 counter stopped at zero");

    // R7: ack clears
    ctrl(32'h0000_7482);
    chk({31'h0, irq_o}, 32'h0, "R7 ack clears irq");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      logic [31:0] d;
      logic [3:0]  a;
      bit          we;
      r  = $urandom_range(0, 99);
      we = (r < 35);
      a  = ($urandom_range(0, 1) == 0) ? 4'h0 : 4'h4;
      case ($urandom_range(0, 7))
        0: d = 32'h3877;
        1: d = 32'h4A4B;
        2: d = 32'h7482;
        3: d = 32'hAB00;
        4: d = 32'hAB01;
        5: d = ($urandom_range(0, 9) == 0) ? 32'hDEAF : 32'h4A4B;
        6: d = {$urandom_range(0, 65535), 16'h0} | 32'($urandom_range(0, 3));
        default: d = $urandom;
      endcase
      if (we && a == 4'h4) d = {16'($urandom), 16'($urandom_range(0, 2))};
      step(we, a, d, ($urandom_range(0, 3) != 0));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule